// File: doc/BRIEF.md
# Low-Power Mode Switchback Controller

This block holds the state of a reduced-clock power management mode and the policy for leaving it. Firmware sets or clears the mode through a write strobe with a data bit. A second write strobe sets or clears an automatic-return enable. While the mode is on, the block drives a clock-divider select code to an external clock generator. When the mode is off, it drives zero.

A fixed set of peripheral conditions counts as wake events, and each counts only when its own qualifier holds:
- masked external interrupt pins;
- a falling edge on the UART receive line;
- UART and SPI transmit-buffer writes;
- SPI slave-select;
- RTC alarms;
- debug entry.

When the automatic-return enable is set and any qualified event occurs, the block clears the mode by itself and emits a one-cycle pulse. A firmware request to enter the mode is dropped while any qualified event is present.

Top module: `lpm_switchback`

## Requirements
- R1: After a synchronous reset, `pmm_active`, `swb_enabled`, `swb_pulse` and `clk_div_sel` are all 0.
- R2: A mode write with data 1 and no qualified event sets `pmm_active` on the next clock edge, with `clk_div_sel` equal to `DIV_CODE`. A mode write with data 0 clears `pmm_active`, and `clk_div_sel` returns to 0.
- R3: A mode write with data 1 made in a cycle where any qualified wake event is present has no effect.
- R4: With switchback disabled (`swb_enabled`=0), qualified wake events leave `pmm_active` at 1.
- R5: With switchback enabled and the mode active, a qualified wake event clears `pmm_active` at the next edge. In that same cycle `swb_pulse` is 1 for exactly one cycle.
- R6: An external interrupt pin `ext_irq[i]` counts as a wake event only while `ext_irq_en[i]` is 1.
- R7: The UART receive line passes through two synchronizing flops and a falling-edge detector. A falling edge counts only while `uart_mode` is not 0 and `uart_rx_en` is 1. With switchback on, the mode clears at the third clock edge after the line falls.
- R8: A UART transmit write (`uart_tx_wr`) counts only while `uart_tx_en` is 1.
- R9: An SPI transmit write counts only while `spi_master`=1 and `spi_tx_en`=1. An asserted `spi_sel` counts only while `spi_master`=0.
- R10: The time-of-day alarm and the subsecond alarm each count only with their own enable. `dbg_enter` always counts.
- R11: When a wake event clears the mode in the same cycle as a firmware mode write of 1, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pmm_wr_en | input | 1 | Mode write strobe |
| pmm_wr_val | input | 1 | Mode write data |
| swb_wr_en | input | 1 | Switchback-enable write strobe |
| swb_wr_val | input | 1 | Switchback-enable write data |
| ext_irq | input | N_IRQ | External interrupt pin conditions |
| ext_irq_en | input | N_IRQ | Per-pin interrupt enables |
| uart_rx | input | 1 | Asynchronous UART receive line, idle high |
| uart_mode | input | 2 | UART mode; 0 disqualifies receive wake |
| uart_rx_en | input | 1 | UART reception enable |
| uart_tx_wr | input | 1 | UART transmit buffer write strobe |
| uart_tx_en | input | 1 | UART transmission enable |
| spi_tx_wr | input | 1 | SPI data buffer write strobe |
| spi_tx_en | input | 1 | SPI transmission enable |
| spi_master | input | 1 | 1 = SPI master, 0 = slave |
| spi_sel | input | 1 | SPI slave-select asserted (active high) |
| rtc_tod_alarm | input | 1 | Time-of-day alarm event |
| rtc_tod_en | input | 1 | Time-of-day alarm enable |
| rtc_sub_alarm | input | 1 | Subsecond alarm event |
| rtc_sub_en | input | 1 | Subsecond alarm enable |
| dbg_enter | input | 1 | Entry into active debug mode |
| pmm_active | output | 1 | Power management mode on |
| swb_enabled | output | 1 | Switchback enable state |
| clk_div_sel | output | DIV_W | Divider select, DIV_CODE in mode else 0 |
| swb_pulse | output | 1 | One-cycle pulse when switchback fires |

## Verification
Two functions can meet in one cycle: an automatic clear caused by a wake event, and a firmware write that asks for the mode. The bench arms the mode with switchback enabled. It then raises a debug entry in the same cycle as a mode write of 1. After that edge it expects `pmm_active` low with `swb_pulse` high. The entry-refusal path is judged the same way: a write of 1 is issued while a qualified interrupt is held, and `pmm_active` must stay at 0.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int WK_IRQ  = 0;
  localparam int WK_URX  = 1;
  localparam int WK_UTX  = 2;
  localparam int WK_SPIM = 3;
  localparam int WK_SSEL = 4;
  localparam int WK_TOD  = 5;
  localparam int WK_SUB  = 6;
  localparam int WK_DBG  = 7;
  localparam int WK_NUM  = 8;
  typedef logic [WK_NUM-1:0] wake_vec_t;
endpackage

// File: rtl/lpm_rx_sync.sv
module lpm_rx_sync (
  input  logic clk,
  input  logic rst,
  input  logic rx_async,
  output logic rx_fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= rx_async;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rx_fall = prev_q & ~s2_q;

  // R7
  rx_fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_fall |=> !rx_fall);
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] ext_irq,
  input  logic [N_IRQ-1:0] ext_irq_en,
  input  logic             rx_fall,
  input  logic [1:0]       uart_mode,
  input  logic             uart_rx_en,
  input  logic             uart_tx_wr,
  input  logic             uart_tx_en,
  input  logic             spi_tx_wr,
  input  logic             spi_tx_en,
  input  logic             spi_master,
  input  logic             spi_sel,
  input  logic             rtc_tod_alarm,
  input  logic             rtc_tod_en,
  input  logic             rtc_sub_alarm,
  input  logic             rtc_sub_en,
  input  logic             dbg_enter,
  output wake_vec_t        wake_vec
);
  logic [N_IRQ-1:0] irq_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    assign irq_hit[i] = ext_irq[i] & ext_irq_en[i];
  end

  always_comb begin
    wake_vec          = '0;
    wake_vec[WK_IRQ]  = |irq_hit;
    wake_vec[WK_URX]  = rx_fall & uart_rx_en & (uart_mode != 2'd0);
    wake_vec[WK_UTX]  = uart_tx_wr & uart_tx_en;
    wake_vec[WK_SPIM] = spi_tx_wr & spi_tx_en & spi_master;
    wake_vec[WK_SSEL] = spi_sel & ~spi_master;
    wake_vec[WK_TOD]  = rtc_tod_alarm & rtc_tod_en;
    wake_vec[WK_SUB]  = rtc_sub_alarm & rtc_sub_en;
    wake_vec[WK_DBG]  = dbg_enter;
  end
endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl #(
  parameter int          DIV_W    = 3,
  parameter int unsigned DIV_CODE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wake_any,
  input  logic             pmm_wr_en,
  input  logic             pmm_wr_val,
  input  logic             swb_wr_en,
  input  logic             swb_wr_val,
  output logic             pmm_q,
  output logic             swb_q,
  output logic [DIV_W-1:0] div_sel_q,
  output logic             pulse_q
);
  localparam logic [DIV_W-1:0] DIV_VAL = DIV_W'(DIV_CODE);

  logic pmm_d, fire;

  always_comb begin
    fire  = pmm_q & swb_q & wake_any;
    pmm_d = pmm_q;
    if (fire)
      pmm_d = 1'b0;
    else if (pmm_wr_en) begin
      if (!pmm_wr_val)
        pmm_d = 1'b0;
      else if (!wake_any)
        pmm_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pmm_q     <= 1'b0;
      swb_q     <= 1'b0;
      div_sel_q <= '0;
      pulse_q   <= 1'b0;
    end else begin
      pmm_q     <= pmm_d;
      div_sel_q <= pmm_d ? DIV_VAL : '0;
      pulse_q   <= fire;
      if (swb_wr_en)
        swb_q <= swb_wr_val;
    end
  end

  // R2
  div_track_chk: assert property (@(posedge clk) disable iff (rst)
    pmm_q |-> div_sel_q == DIV_VAL);
  // R3
  no_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!pmm_q && wake_any) |=> !pmm_q);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pmm_q && !swb_q && !(pmm_wr_en && !pmm_wr_val)) |=> pmm_q);
  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);
  // R11
  wake_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (pmm_q && swb_q && wake_any) |=> (!pmm_q && pulse_q));
endmodule

// File: rtl/lpm_switchback.sv
module lpm_switchback
  import lpm_pkg::*;
#(
  parameter int          N_IRQ    = 4,
  parameter int          DIV_W    = 3,
  parameter int unsigned DIV_CODE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pmm_wr_en,
  input  logic             pmm_wr_val,
  input  logic             swb_wr_en,
  input  logic             swb_wr_val,
  input  logic [N_IRQ-1:0] ext_irq,
  input  logic [N_IRQ-1:0] ext_irq_en,
  input  logic             uart_rx,
  input  logic [1:0]       uart_mode,
  input  logic             uart_rx_en,
  input  logic             uart_tx_wr,
  input  logic             uart_tx_en,
  input  logic             spi_tx_wr,
  input  logic             spi_tx_en,
  input  logic             spi_master,
  input  logic             spi_sel,
  input  logic             rtc_tod_alarm,
  input  logic             rtc_tod_en,
  input  logic             rtc_sub_alarm,
  input  logic             rtc_sub_en,
  input  logic             dbg_enter,
  output logic             pmm_active,
  output logic             swb_enabled,
  output logic [DIV_W-1:0] clk_div_sel,
  output logic             swb_pulse
);
  logic      rx_fall;
  wake_vec_t wake_vec;

  lpm_rx_sync u_rx (
    .clk     (clk),
    .rst     (rst),
    .rx_async(uart_rx),
    .rx_fall (rx_fall)
  );

  lpm_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
    .ext_irq      (ext_irq),
    .ext_irq_en   (ext_irq_en),
    .rx_fall      (rx_fall),
    .uart_mode    (uart_mode),
    .uart_rx_en   (uart_rx_en),
    .uart_tx_wr   (uart_tx_wr),
    .uart_tx_en   (uart_tx_en),
    .spi_tx_wr    (spi_tx_wr),
    .spi_tx_en    (spi_tx_en),
    .spi_master   (spi_master),
    .spi_sel      (spi_sel),
    .rtc_tod_alarm(rtc_tod_alarm),
    .rtc_tod_en   (rtc_tod_en),
    .rtc_sub_alarm(rtc_sub_alarm),
    .rtc_sub_en   (rtc_sub_en),
    .dbg_enter    (dbg_enter),
    .wake_vec     (wake_vec)
  );

  lpm_mode_ctrl #(.DIV_W(DIV_W), .DIV_CODE(DIV_CODE)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wake_any  (|wake_vec),
    .pmm_wr_en (pmm_wr_en),
    .pmm_wr_val(pmm_wr_val),
    .swb_wr_en (swb_wr_en),
    .swb_wr_val(swb_wr_val),
    .pmm_q     (pmm_active),
    .swb_q     (swb_enabled),
    .div_sel_q (clk_div_sel),
    .pulse_q   (swb_pulse)
  );

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (pmm_active && swb_enabled && (ext_irq & ext_irq_en) != '0) |=> !pmm_active);
endmodule

// File: tb/sim_lpm_switchback.sv
module sim_lpm_switchback;
  localparam int N_IRQ = 4;
  localparam int DIV_W = 3;
  localparam int unsigned DIV_CODE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pmm_wr_en = 0, pmm_wr_val = 0, swb_wr_en = 0, swb_wr_val = 0;
  logic [N_IRQ-1:0] ext_irq = '0, ext_irq_en = '0;
  logic uart_rx = 1'b1;
  logic [1:0] uart_mode = 2'd0;
  logic uart_rx_en = 0, uart_tx_wr = 0, uart_tx_en = 0;
  logic spi_tx_wr = 0, spi_tx_en = 0, spi_master = 0, spi_sel = 0;
  logic rtc_tod_alarm = 0, rtc_tod_en = 0, rtc_sub_alarm = 0, rtc_sub_en = 0;
  logic dbg_enter = 0;
  logic pmm_active, swb_enabled, swb_pulse;
  logic [DIV_W-1:0] clk_div_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpm_switchback #(.N_IRQ(N_IRQ), .DIV_W(DIV_W), .DIV_CODE(DIV_CODE)) u0 (
    .clk(clk), .rst(rst),
    .pmm_wr_en(pmm_wr_en), .pmm_wr_val(pmm_wr_val),
    .swb_wr_en(swb_wr_en), .swb_wr_val(swb_wr_val),
    .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
    .uart_rx(uart_rx), .uart_mode(uart_mode), .uart_rx_en(uart_rx_en),
    .uart_tx_wr(uart_tx_wr), .uart_tx_en(uart_tx_en),
    .spi_tx_wr(spi_tx_wr), .spi_tx_en(spi_tx_en),
    .spi_master(spi_master), .spi_sel(spi_sel),
    .rtc_tod_alarm(rtc_tod_alarm), .rtc_tod_en(rtc_tod_en),
    .rtc_sub_alarm(rtc_sub_alarm), .rtc_sub_en(rtc_sub_en),
    .dbg_enter(dbg_enter),
    .pmm_active(pmm_active), .swb_enabled(swb_enabled),
    .clk_div_sel(clk_div_sel), .swb_pulse(swb_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_mode(input logic v);
    pmm_wr_en = 1; pmm_wr_val = v;
    step();
    pmm_wr_en = 0; pmm_wr_val = 0;
  endtask

  task automatic arm();
    swb_wr_en = 1; swb_wr_val = 1;
    pmm_wr_en = 1; pmm_wr_val = 1;
    step();
    swb_wr_en = 0; pmm_wr_en = 0; pmm_wr_val = 0;
  endtask

  task automatic drive_src(input int src, input logic v);
    case (src)
      0: ext_irq[1] = v;
      1: uart_tx_wr = v;
      2: spi_tx_wr = v;
      3: spi_sel = v;
      4: rtc_tod_alarm = v;
      5: rtc_sub_alarm = v;
      default: dbg_enter = v;
    endcase
  endtask

  task automatic wake_case(input int src, input logic exp_exit, input string req);
    arm();
    chk(req, int'(pmm_active), 1);
    drive_src(src, 1'b1);
    step();
    drive_src(src, 1'b0);
    chk(req, int'(pmm_active), int'(!exp_exit));
    chk(req, int'(swb_pulse), int'(exp_exit));
    step();
    chk(req, int'(swb_pulse), 0);
    wr_mode(1'b0);
  endtask

  task automatic t_reset();
    chk("R1", int'(pmm_active), 0);
    chk("R1", int'(swb_enabled), 0);
    chk("R1", int'(clk_div_sel), 0);
    chk("R1", int'(swb_pulse), 0);
  endtask

  task automatic t_entry();
    wr_mode(1'b1);
    chk("R2", int'(pmm_active), 1);
    chk("R2", int'(clk_div_sel), int'(DIV_CODE));
    wr_mode(1'b0);
    chk("R2", int'(pmm_active), 0);
    chk("R2", int'(clk_div_sel), 0);
  endtask

  task automatic t_refuse();
    ext_irq_en = 4'b0010;
    ext_irq[1] = 1;
    wr_mode(1'b1);
    chk("R3", int'(pmm_active), 0);
    ext_irq_en = 4'b0000;
    wr_mode(1'b1);
    chk("R6", int'(pmm_active), 1);
    ext_irq[1] = 0;
    wr_mode(1'b0);
  endtask

  task automatic t_noswb();
    uart_tx_en = 1;
    wr_mode(1'b1);
    uart_tx_wr = 1;
    step();
    uart_tx_wr = 0;
    chk("R4", int'(pmm_active), 1);
    chk("R4", int'(swb_pulse), 0);
    wr_mode(1'b0);
    uart_tx_en = 0;
  endtask

  task automatic t_sources();
    ext_irq_en = 4'b0000; wake_case(0, 1'b0, "R6");
    ext_irq_en = 4'b0010; wake_case(0, 1'b1, "R6");
    ext_irq_en = 4'b0000;
    uart_tx_en = 0; wake_case(1, 1'b0, "R8");
    uart_tx_en = 1; wake_case(1, 1'b1, "R8");
    uart_tx_en = 0;
    spi_master = 1; spi_tx_en = 0; wake_case(2, 1'b0, "R9");
    spi_master = 0; spi_tx_en = 1; wake_case(2, 1'b0, "R9");
    spi_master = 1; spi_tx_en = 1; wake_case(2, 1'b1, "R9");
    spi_master = 1; wake_case(3, 1'b0, "R9");
    spi_master = 0; wake_case(3, 1'b1, "R9");
    spi_tx_en = 0;
    rtc_tod_en = 0; wake_case(4, 1'b0, "R10");
    rtc_tod_en = 1; wake_case(4, 1'b1, "R10");
    rtc_tod_en = 0;
    rtc_sub_en = 0; wake_case(5, 1'b0, "R10");
    rtc_sub_en = 1; wake_case(5, 1'b1, "R10");
    rtc_sub_en = 0;
    wake_case(6, 1'b1, "R10");
  endtask

  task automatic rx_case(input logic [1:0] mode, input logic en, input logic exp_exit);
    uart_mode = mode; uart_rx_en = en;
    arm();
    uart_rx = 0;
    step();
    step();
    chk("R7", int'(pmm_active), 1);
    step();
    chk("R7", int'(pmm_active), int'(!exp_exit));
    chk("R5", int'(swb_pulse), int'(exp_exit));
    step();
    chk("R5", int'(swb_pulse), 0);
    uart_rx = 1;
    step(); step(); step();
    chk("R7", int'(pmm_active), int'(!exp_exit));
    wr_mode(1'b0);
    uart_mode = 2'd0; uart_rx_en = 0;
  endtask

  task automatic t_collide();
    arm();
    dbg_enter = 1;
    pmm_wr_en = 1; pmm_wr_val = 1;
    step();
    dbg_enter = 0; pmm_wr_en = 0; pmm_wr_val = 0;
    chk("R11", int'(pmm_active), 0);
    chk("R11", int'(swb_pulse), 1);
    chk("R11", int'(clk_div_sel), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_entry();
    t_refuse();
    t_noswb();
    t_sources();
    rx_case(2'd1, 1'b1, 1'b1);
    rx_case(2'd0, 1'b1, 1'b0);
    rx_case(2'd3, 1'b0, 1'b0);
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule